// File: doc/BRIEF.md
# Upstream D-Channel Access Arbiter

This block decides when a local HDLC transmitter may drive the shared upstream D channel of an S/T bus. It follows the same contention rules that terminals use among themselves. On each D-bit slot, marked by a strobe, it counts consecutive ones seen on the line. It raises `grant` once that count reaches the threshold for the selected priority class and the current level. It also produces the E bit that is echoed back downstream.

Access is granted at once when the line is not in a state where contention applies, or when software forces it. The line is not in such a state when the interface is disabled, when INFO 3 is not being received, or when force-activate is set. Forced access through the force-D bit also inverts the echoed E bit. Any terminal that is transmitting then sees a collision and backs off. After a packet won by counting, the level drops to the lowered setting. The level goes back to normal by itself once a lowered-level run of ones has been seen. The grant is held until the transmitter reports that its packet is done.

Top module: `dch_access_arbiter`

## Requirements
- R1: While the interface is disabled (`if_enable`=0), INFO 3 is absent (`info3_active`=0), or `force_act`=1, an idle arbiter raises `grant` at the next clock edge, with no strobe needed.
- R2: While `force_d`=1, an idle arbiter raises `grant` at the next clock edge.
- R3: With `class_sel`=0 (class 1) and no force, `grant` rises at the strobe edge that brings the run of ones to 8 at the normal level, or to 9 at the lowered level.
- R4: With `class_sel`=1 (class 2) and no force, `grant` rises at the strobe edge that brings the run of ones to 10 at the normal level, or to 11 at the lowered level.
- R5: Releasing a grant that was won by counting sets the lowered level. The level goes back to normal at the strobe edge where the run of ones reaches the lowered threshold, whether or not a grant is held. Releasing a forced grant leaves the level unchanged.
- R6: The run of ones changes only on edges where `d_strobe`=1. A strobed zero resets it to 0, and it saturates at its maximum instead of wrapping.
- R7: `e_echo` equals `d_up` while `force_d`=0 and equals the inverse of `d_up` while `force_d`=1, with no clock delay.
- R8: Once raised, `grant` stays high until a clock edge with `pkt_done`=1. It is low after that edge, and the run of ones is cleared at the same edge.
- R9: A clock edge with `rst`=1 clears `grant` and the run of ones and sets the normal level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| d_strobe | input | 1 | One-cycle pulse marking a valid upstream D-bit sample |
| d_up | input | 1 | Upstream D bit received from the bus |
| info3_active | input | 1 | High while INFO 3 is being received |
| if_enable | input | 1 | Interface enable |
| force_act | input | 1 | Force-activate control |
| force_d | input | 1 | Force D-channel access to the local transmitter |
| class_sel | input | 1 | Priority class: 0 = class 1, 1 = class 2 |
| pkt_done | input | 1 | Transmitter signals that its packet is complete |
| grant | output | 1 | Local transmitter owns the upstream D channel |
| e_echo | output | 1 | E bit echoed downstream |

## Verification
The assertions watch four behaviours on every cycle. A forced condition must lead to a grant. A grant must hold until `pkt_done` and then release. A strobed zero must clear the run of ones, and the counter must never wrap. Releasing a grant won by counting must leave the level lowered, and reset must return everything to its initial state. The exact edge at which a counted grant appears cannot be seen from one cycle alone, because it depends on the history of the class and the level. The bench scenarios show it, along with the automatic return to the normal level, the class-2 thresholds, and the echo inversion at the ports.

// File: rtl/dch_access_arbiter.sv
`timescale 1ns/1ps
module dch_access_arbiter #(
  parameter int CNT_W    = 4,
  parameter int CLS1_THR = 8,
  parameter int CLS2_THR = 10,
  parameter int LOW_STEP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_strobe,
  input  logic d_up,
  input  logic info3_active,
  input  logic if_enable,
  input  logic force_act,
  input  logic force_d,
  input  logic class_sel,
  input  logic pkt_done,
  output logic grant,
  output logic e_echo
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] ones_cnt, cnt_next;
  logic             lowered, won_by_count;

  wire forced      = !if_enable || !info3_active || force_act || force_d;
  wire release_now = grant && pkt_done;

  wire [CNT_W-1:0] thr_norm = class_sel ? CNT_W'(CLS2_THR) : CNT_W'(CLS1_THR);
  wire [CNT_W-1:0] thr_low  = thr_norm + CNT_W'(LOW_STEP);
  wire [CNT_W-1:0] thr_now  = lowered ? thr_low : thr_norm;

  always_comb begin
    cnt_next = ones_cnt;
    if (d_strobe) begin
      if (!d_up)                 cnt_next = '0;
      else if (ones_cnt != CNT_MAX) cnt_next = ones_cnt + 1'b1;
    end
  end

  wire run_hit_now = d_strobe && d_up && (cnt_next >= thr_now);
  wire run_hit_low = d_strobe && d_up && (cnt_next >= thr_low);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant        <= 1'b0;
      won_by_count <= 1'b0;
      lowered      <= 1'b0;
      ones_cnt     <= '0;
    end else if (release_now) begin
      grant        <= 1'b0;
      won_by_count <= 1'b0;
      ones_cnt     <= '0;
      if (won_by_count) lowered <= 1'b1;
    end else begin
      ones_cnt <= cnt_next;
      if (lowered && run_hit_low) lowered <= 1'b0;
      if (!grant) begin
        if (forced) begin
          grant        <= 1'b1;
          won_by_count <= 1'b0;
        end else if (run_hit_now) begin
          grant        <= 1'b1;
          won_by_count <= 1'b1;
        end
      end
    end
  end

  assign e_echo = force_d ? ~d_up : d_up;

  p_forced_grant_r1: assert property (@(posedge clk) disable iff (rst)
    ((!if_enable || !info3_active || force_act) && !(grant && pkt_done)) |=> grant);

  p_force_d_grant_r2: assert property (@(posedge clk) disable iff (rst)
    (force_d && !(grant && pkt_done)) |=> grant);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (grant && !pkt_done) |=> grant);

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (grant && pkt_done) |=> (!grant && ones_cnt == '0));

  p_zero_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (d_strobe && !d_up) |=> (ones_cnt == '0));

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (d_strobe && d_up && ones_cnt == CNT_MAX && !(grant && pkt_done)) |=> (ones_cnt == CNT_MAX));

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!d_strobe && !(grant && pkt_done)) |=> $stable(ones_cnt));

  p_lower_after_win_r5: assert property (@(posedge clk) disable iff (rst)
    (grant && pkt_done && won_by_count) |=> lowered);

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (!grant && !lowered && ones_cnt == '0));
endmodule

// File: tb/tb_dch_access_arbiter.sv
`timescale 1ns/1ps
module tb_dch_access_arbiter;
  logic clk = 1'b0;
  logic rst, d_strobe, d_up, info3_active, if_enable, force_act, force_d, class_sel, pkt_done;
  logic grant, e_echo;
  int   n_checks = 0;
  int   n_fails  = 0;

  always #2.5 clk = ~clk;

  dch_access_arbiter dut (
    .clk(clk), .rst(rst), .d_strobe(d_strobe), .d_up(d_up),
    .info3_active(info3_active), .if_enable(if_enable), .force_act(force_act),
    .force_d(force_d), .class_sel(class_sel), .pkt_done(pkt_done),
    .grant(grant), .e_echo(e_echo)
  );

  // {rep[4:0], rst,stb,d,i3,en,fa,fd,cls,done, exp_grant,exp_e}
  localparam int NV = 17;
  localparam logic [15:0] VEC [NV] = '{
    {5'd1,  9'b1_0_1_1_1_0_0_0_0, 2'b0_1},  // R9 reset state
    {5'd9,  9'b0_1_1_1_1_0_0_1_0, 2'b0_1},  // R4 class 2 normal, below 10
    {5'd1,  9'b0_1_1_1_1_0_0_1_0, 2'b1_1},  // R4 tenth one grants
    {5'd1,  9'b0_0_1_1_1_0_0_1_1, 2'b0_1},  // R8 release, R5 lowered
    {5'd8,  9'b0_1_1_1_1_0_0_0_0, 2'b0_1},  // R3 class 1 lowered, 8 not enough
    {5'd1,  9'b0_1_0_1_1_0_0_0_0, 2'b0_0},  // R6 zero resets run
    {5'd8,  9'b0_1_1_1_1_0_0_0_0, 2'b0_1},  // R6 run restarted
    {5'd1,  9'b0_1_1_1_1_0_0_0_0, 2'b1_1},  // R3 ninth one grants when lowered
    {5'd1,  9'b0_0_1_1_1_0_0_0_1, 2'b0_1},  // R8 release, lowered again
    {5'd9,  9'b0_1_1_1_1_0_1_0_0, 2'b1_0},  // R2 forced, R7 inverted echo, R5 restore
    {5'd1,  9'b0_0_1_1_1_0_0_0_1, 2'b0_1},  // R5 forced release keeps normal
    {5'd7,  9'b0_1_1_1_1_0_0_0_0, 2'b0_1},  // R5 normal level counting
    {5'd1,  9'b0_1_1_1_1_0_0_0_0, 2'b1_1},  // R5 grant at 8 proves normal
    {5'd1,  9'b0_0_1_1_1_0_0_0_1, 2'b0_1},  // R8 release, lowered
    {5'd10, 9'b0_1_1_1_1_0_0_1_0, 2'b0_1},  // R4 class 2 lowered, below 11
    {5'd1,  9'b0_1_1_1_1_0_0_1_0, 2'b1_1},  // R4 eleventh one grants
    {5'd1,  9'b0_0_1_1_1_0_0_1_1, 2'b0_1}   // R8 release
  };

  task automatic drive(input logic [8:0] v);
    @(negedge clk);
    {rst, d_strobe, d_up, info3_active, if_enable, force_act, force_d, class_sel, pkt_done} = v;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic exp_g, input logic exp_e);
    n_checks++;
    if (grant !== exp_g) begin
      n_fails++;
      $display("FAIL %s grant actual=%b expected=%b", req, grant, exp_g);
    end
    n_checks++;
    if (e_echo !== exp_e) begin
      n_fails++;
      $display("FAIL %s e_echo actual=%b expected=%b", req, e_echo, exp_e);
    end
  endtask

  initial begin
    {rst, d_strobe, d_up, info3_active, if_enable, force_act, force_d, class_sel, pkt_done} = 9'b1_0_1_1_1_0_0_0_0;
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i][15:11]); k++) begin
        drive(VEC[i][10:2]);
        check($sformatf("vector %0d", i), VEC[i][1], VEC[i][0]);
      end
    end

    // R9: reset returns to normal level (state was lowered)
    drive(9'b1_0_1_1_1_0_0_0_0); check("R9 reset", 1'b0, 1'b1);
    for (int k = 0; k < 7; k++) begin
      drive(9'b0_1_1_1_1_0_0_0_0); check("R9 normal after reset", 1'b0, 1'b1);
    end
    drive(9'b0_1_1_1_1_0_0_0_0); check("R9 grant at 8 after reset", 1'b1, 1'b1);
    drive(9'b0_0_1_1_1_0_0_0_1); check("R8 release", 1'b0, 1'b1);

    // R6: no strobe, no counting
    for (int k = 0; k < 12; k++) begin
      drive(9'b0_0_1_1_1_0_0_0_0); check("R6 unstrobed ones ignored", 1'b0, 1'b1);
    end

    // R1: INFO 3 absent, then hold (R8)
    drive(9'b0_0_1_0_1_0_0_0_0); check("R1 info3 absent", 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      drive(9'b0_0_1_1_1_0_0_0_0); check("R8 hold after force gone", 1'b1, 1'b1);
    end
    drive(9'b0_0_1_1_1_0_0_0_1); check("R8 release", 1'b0, 1'b1);

    // R1: interface disabled, re-arbitration after release
    drive(9'b0_0_1_1_0_0_0_0_0); check("R1 disabled", 1'b1, 1'b1);
    drive(9'b0_0_1_1_0_0_0_0_1); check("R8 release while disabled", 1'b0, 1'b1);
    drive(9'b0_0_1_1_0_0_0_0_0); check("R1 regrant while disabled", 1'b1, 1'b1);
    drive(9'b0_0_1_1_1_0_0_0_1); check("R8 release", 1'b0, 1'b1);

    // R1: force-activate
    drive(9'b0_0_1_1_1_1_0_0_0); check("R1 force activate", 1'b1, 1'b1);
    drive(9'b0_0_1_1_1_0_0_0_1); check("R8 release", 1'b0, 1'b1);

    // R7: echo with and without force-D
    drive(9'b0_0_0_1_1_0_1_0_0); check("R7 inverted zero", 1'b1, 1'b1);
    drive(9'b0_0_1_1_1_0_1_0_0); check("R7 inverted one", 1'b1, 1'b0);
    drive(9'b0_0_0_1_1_0_0_0_1); check("R7 plain zero", 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1000000;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule